// File: doc/BRIEF.md
# 8-bit PWM and interval timer

This block is an 8-bit up-counter with a period register and a duty register, driven by a one-cycle count-tick enable that some neighbouring prescaler supplies. In interval mode the counter runs from 00H up to the period value, wraps to 00H on the tick that finds them equal, pulses the interrupt and flips the output. The result is a periodic interrupt and a square wave with a half-period of period+1 ticks.

In PWM mode a single comparator alternates between the two registers. A period match starts the active phase, clears the counter and points the comparator at the duty register. A duty match ends the active phase and points it back at the period register. A new duty value is held in a buffer and moved into the compare path only at the next period match, so no waveform cycle is ever cut short or stretched. The output polarity and the output drive are chosen per mode write. The 3-bit clock-select field is stored and brought out unchanged for the external divider.

Top module: `pwm_ivl_timer`

## Requirements
- R1: After reset the output pin is 0, the interrupt is 0 and the clock-select output is 0.
- R2: While the run bit (mode bit 7) is 0 the counter does not count, no interrupt is raised and the active phase is cleared. After the run bit is set again, the first period match comes period+1 ticks later.
- R3: In interval mode (mode bits 3:2 with bit 3 = 0), a tick that finds counter == period raises the interrupt for one cycle, clears the counter and toggles the output. Interrupts therefore repeat every period+1 ticks.
- R4: The counter advances only on cycles where the count-tick enable is 1.
- R5: In PWM mode (mode bit 3 = 1) the output is active for duty+1 ticks in each cycle of period+1 ticks. The active phase begins at a period match, which also raises the interrupt. The duty value must stay below the period value.
- R6: A duty value of 00H gives an active phase one tick long.
- R7: A duty write takes effect only at the next period match. The waveform cycle already under way keeps the old duty.
- R8: The polarity bit (mode bit 1) set to 1 makes the active level low and the inactive level high.
- R9: With the drive-enable bit (mode bit 0) at 0, the pin holds the inactive level whatever the counter does.
- R10: Reset clears both compare registers to 00H. Enabling interval mode without writing them gives an interrupt on every tick.
- R11: Mode bits 6:4 are stored at a mode write and presented on the clock-select output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode value: run, clock select[2:0], mode[1:0], polarity, drive enable |
| period_wr | input | 1 | Write strobe for the period register |
| period_wdata | input | 8 | New period value |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_wdata | input | 8 | New duty value |
| tick_en | input | 1 | Count-tick enable, one cycle per count |
| clk_sel | output | 3 | Stored clock-select field |
| tmr_pin | output | 1 | Timer output pin |
| tmr_irq | output | 1 | Interrupt pulse at each period match |

## Verification
The assertions assume that software keeps the duty value strictly below the period value whenever the block runs in PWM mode. One property flags any departure from this. The bench respects it by writing period and duty before it sets the run bit, and by choosing later duty updates below the period. Mode changes are made only while stopped or straight after reset, so no property has to reason about a mode flip in the middle of a waveform cycle.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic [1:0] {
    TM_IVL     = 2'b00,
    TM_IVL_ALT = 2'b01,
    TM_PWM     = 2'b10,
    TM_PWM_ALT = 2'b11
  } tmr_mode_e;

  // Mode register layout, bit 7 down to bit 0.
  typedef struct packed {
    logic      run;
    logic [2:0] cksel;
    tmr_mode_e mode;
    logic      act_low;
    logic      drv_en;
  } tmr_ctl_t;

  function automatic logic is_pwm(input tmr_mode_e m);
    return m[1];
  endfunction

  // Pin level: the active phase is XORed with the polarity, and the inactive
  // level is driven when drive is off.
  function automatic logic pin_level(input logic act, input logic act_low,
                                     input logic drv_en);
    return drv_en ? (act ^ act_low) : act_low;
  endfunction

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [7:0]       mode_wdata,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             ev_per,
  output tmr_ctl_t         ctl_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] duty_buf_q,
  output logic [CNT_W-1:0] duty_act_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (mode_wr) begin
      ctl_q <= tmr_ctl_t'(mode_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (period_wr) begin
      period_q <= period_wdata;
    end
  end

  // Duty is double-buffered: software writes the buffer, and the compare path
  // picks it up on a period match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_buf_q <= '0;
    end else if (duty_wr) begin
      duty_buf_q <= duty_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= '0;
    end else if (ev_per) begin
      duty_act_q <= duty_buf_q;
    end
  end

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwm,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt_q,
  output logic             duty_phase_q,
  output logic             ev_per,
  output logic             ev_duty
);

  logic [CNT_W-1:0] cmp_val;
  logic             hit;
  logic [CNT_W-1:0] cnt_d;
  logic             phase_d;

  // One comparator; its operand swaps with the phase.
  assign cmp_val = duty_phase_q ? duty : period;
  assign hit     = run && tick && (cnt_q == cmp_val);
  assign ev_per  = hit && !duty_phase_q;
  assign ev_duty = hit && duty_phase_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = ev_per ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    phase_d = duty_phase_q;
    if (!run || !pwm) begin
      phase_d = 1'b0;
    end else if (ev_per) begin
      phase_d = 1'b1;
    end else if (ev_duty) begin
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      duty_phase_q <= 1'b0;
    end else begin
      cnt_q        <= cnt_d;
      duty_phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
  import pwm_tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pwm,
  input  logic act_low,
  input  logic drv_en,
  input  logic ev_per,
  input  logic ev_duty,
  output logic act_q,
  output logic pin,
  output logic irq_q
);

  logic act_d;

  always_comb begin
    act_d = act_q;
    if (!run) begin
      act_d = 1'b0;
    end else if (pwm) begin
      if (ev_per) begin
        act_d = 1'b1;
      end else if (ev_duty) begin
        act_d = 1'b0;
      end
    end else if (ev_per) begin
      act_d = ~act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      act_q <= act_d;
      irq_q <= ev_per;
    end
  end

  assign pin = pin_level(act_q, act_low, drv_en);

endmodule

// File: rtl/pwm_ivl_timer.sv
module pwm_ivl_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [7:0]       mode_wdata,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             tick_en,
  output logic [2:0]       clk_sel,
  output logic             tmr_pin,
  output logic             tmr_irq
);

  tmr_ctl_t         ctl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] duty_buf_q;
  logic [CNT_W-1:0] duty_act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             duty_phase_q;
  logic             ev_per;
  logic             ev_duty;
  logic             act_q;
  logic             run;
  logic             pwm;

  assign run     = ctl_q.run;
  assign pwm     = is_pwm(ctl_q.mode);
  assign clk_sel = ctl_q.cksel;

  tmr_cfg_regs #(.CNT_W(CNT_W)) cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .period_wr    (period_wr),
    .period_wdata (period_wdata),
    .duty_wr      (duty_wr),
    .duty_wdata   (duty_wdata),
    .ev_per       (ev_per),
    .ctl_q        (ctl_q),
    .period_q     (period_q),
    .duty_buf_q   (duty_buf_q),
    .duty_act_q   (duty_act_q)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) cnt_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .pwm          (pwm),
    .tick         (tick_en),
    .period       (period_q),
    .duty         (duty_act_q),
    .cnt_q        (cnt_q),
    .duty_phase_q (duty_phase_q),
    .ev_per       (ev_per),
    .ev_duty      (ev_duty)
  );

  tmr_wave_out wave_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .pwm     (pwm),
    .act_low (ctl_q.act_low),
    .drv_en  (ctl_q.drv_en),
    .ev_per  (ev_per),
    .ev_duty (ev_duty),
    .act_q   (act_q),
    .pin     (tmr_pin),
    .irq_q   (tmr_irq)
  );

endmodule

// File: rtl/pwm_ivl_timer_chk.sv
module pwm_ivl_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             pwm,
  input logic             tick_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] duty_buf_q,
  input logic [CNT_W-1:0] duty_act_q,
  input logic             ev_per,
  input logic             ev_duty,
  input logic             act_q,
  input logic             tmr_irq
);

  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ev_per);

  p_match_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_per |=> (cnt_q == '0));

  p_irq_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_per |=> tmr_irq);

  p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> $past(ev_per));

  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_en) |=> $stable(cnt_q));

  p_pwm_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_per && pwm) |=> act_q);

  p_pwm_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_duty && run) |=> !act_q);

  p_duty_below_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pwm && ev_per) |-> (duty_buf_q < period_q));

  p_duty_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_per |=> $stable(duty_act_q));

  p_duty_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_per |=> (duty_act_q == $past(duty_buf_q)));

endmodule

bind pwm_ivl_timer pwm_ivl_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .pwm        (pwm),
  .tick_en    (tick_en),
  .cnt_q      (cnt_q),
  .period_q   (period_q),
  .duty_buf_q (duty_buf_q),
  .duty_act_q (duty_act_q),
  .ev_per     (ev_per),
  .ev_duty    (ev_duty),
  .act_q      (act_q),
  .tmr_irq    (tmr_irq)
);

// File: tb/pwm_ivl_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_ivl_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [7:0] mode_wdata;
  logic       period_wr;
  logic [7:0] period_wdata;
  logic       duty_wr;
  logic [7:0] duty_wdata;
  logic       tick_en;
  logic [2:0] clk_sel;
  logic       tmr_pin;
  logic       tmr_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_ivl_timer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .period_wr    (period_wr),
    .period_wdata (period_wdata),
    .duty_wr      (duty_wr),
    .duty_wdata   (duty_wdata),
    .tick_en      (tick_en),
    .clk_sel      (clk_sel),
    .tmr_pin      (tmr_pin),
    .tmr_irq      (tmr_irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = '0; period_wr = 1'b0;
    period_wdata = '0; duty_wr = 1'b0; duty_wdata = '0; tick_en = 1'b1;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v; step(); mode_wr = 1'b0;
  endtask

  task automatic wr_period(input logic [7:0] v);
    period_wr = 1'b1; period_wdata = v; step(); period_wr = 1'b0;
  endtask

  task automatic wr_duty(input logic [7:0] v);
    duty_wr = 1'b1; duty_wdata = v; step(); duty_wr = 1'b0;
  endtask

  // Expected PWM active phase at sample i after the run write:
  // the first period match is at i = p+1, cycle length p+1, active d+1.
  function automatic int pwm_act(input int i, input int p, input int d);
    if (i < p + 1) return 0;
    return (((i - (p + 1)) % (p + 1)) < (d + 1)) ? 1 : 0;
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk("R1 pin after reset", tmr_pin, 0);
    chk("R1 irq after reset", tmr_irq, 0);
    chk("R1 clk_sel after reset", clk_sel, 0);
  endtask

  task automatic t_cleared_compare();
    do_reset();
    wr_mode(8'h81);
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R10 irq every tick with reset period", tmr_irq, 1);
      chk("R10 pin toggles every tick", tmr_pin, i % 2);
    end
  endtask

  task automatic t_interval();
    do_reset();
    wr_period(8'd4);
    wr_mode(8'hD1);
    chk("R11 clk_sel stored", clk_sel, 5);
    for (int i = 1; i <= 20; i++) begin
      step();
      chk("R3 interval irq", tmr_irq, (i % 5 == 0) ? 1 : 0);
      chk("R3 interval pin", tmr_pin, (i / 5) % 2);
    end
  endtask

  task automatic t_tick_gate();
    do_reset();
    wr_period(8'd2);
    wr_mode(8'h81);
    for (int i = 1; i <= 18; i++) begin
      tick_en = (i % 2 == 1);
      step();
      chk("R4 irq with gated ticks", tmr_irq, (i % 6 == 5) ? 1 : 0);
    end
    tick_en = 1'b1;
  endtask

  task automatic t_stop_restart();
    do_reset();
    wr_period(8'd3);
    wr_mode(8'h81);
    for (int i = 1; i <= 5; i++) step();
    chk("R3 pin toggled before stop", tmr_pin, 1);
    wr_mode(8'h01);
    for (int i = 1; i <= 5; i++) begin
      step();
      chk("R2 no irq while stopped", tmr_irq, 0);
      chk("R2 pin inactive while stopped", tmr_pin, 0);
    end
    wr_mode(8'h81);
    for (int i = 1; i <= 4; i++) begin
      step();
      chk("R2 restart from zero", tmr_irq, (i == 4) ? 1 : 0);
    end
  endtask

  task automatic t_pwm_basic();
    do_reset();
    wr_period(8'd7);
    wr_duty(8'd2);
    wr_mode(8'h89);
    for (int i = 1; i <= 40; i++) begin
      step();
      chk("R5 pwm pin", tmr_pin, pwm_act(i, 7, 2));
      chk("R5 pwm irq", tmr_irq, (i >= 8 && i % 8 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_pwm_zero_duty();
    do_reset();
    wr_period(8'd4);
    wr_duty(8'd0);
    wr_mode(8'h89);
    for (int i = 1; i <= 25; i++) begin
      step();
      chk("R6 zero duty pin", tmr_pin, pwm_act(i, 4, 0));
    end
  endtask

  task automatic t_polarity_drive();
    do_reset();
    wr_period(8'd7);
    wr_duty(8'd2);
    wr_mode(8'h8B);
    for (int i = 1; i <= 24; i++) begin
      step();
      chk("R8 active-low pin", tmr_pin, 1 - pwm_act(i, 7, 2));
    end
    do_reset();
    wr_period(8'd7);
    wr_duty(8'd2);
    wr_mode(8'h8A);
    for (int i = 1; i <= 20; i++) begin
      step();
      chk("R9 drive off holds high inactive", tmr_pin, 1);
    end
    do_reset();
    wr_period(8'd7);
    wr_duty(8'd2);
    wr_mode(8'h88);
    for (int i = 1; i <= 20; i++) begin
      step();
      chk("R9 drive off holds low inactive", tmr_pin, 0);
    end
  endtask

  task automatic t_duty_deferred();
    int e;
    do_reset();
    wr_period(8'd7);
    wr_duty(8'd2);
    wr_mode(8'h89);
    for (int i = 1; i <= 31; i++) begin
      if (i == 10) begin duty_wr = 1'b1; duty_wdata = 8'd5; end
      step();
      duty_wr = 1'b0;
      if (i < 16) e = pwm_act(i, 7, 2);
      else        e = ((i - 16) % 8 < 6) ? 1 : 0;
      chk("R7 deferred duty pin", tmr_pin, e);
    end
  endtask

  initial begin
    t_reset_state();
    t_cleared_compare();
    t_interval();
    t_tick_gate();
    t_stop_restart();
    t_pwm_basic();
    t_pwm_zero_duty();
    t_polarity_drive();
    t_duty_deferred();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule